// File: doc/BRIEF.md
# Dual Recursive Systematic Encoder with Rate Puncturing

This block is the coding datapath of a parallel concatenated convolutional code. Two identical recursive systematic convolutional encoders run in lockstep. One consumes the data block in its natural order. The other consumes the same block after permutation. The permutation and the block storage sit outside this block, so the source presents each natural-order bit and its permuted partner together on one valid strobe.

For every accepted pair, an output multiplexer emits a group of 2, 3, 4 or 6 coded bits, one per clock on a serial output with its own valid. A two-bit rate select picks the puncturing pattern. The source marks the final pair with a last flag. After that pair's group has been sent, the block terminates encoder 1 and then encoder 2. Each termination lasts as many steps as the encoder memory, drives the register back to all zeros, and emits three tail bits per step whatever the rate.

The memory depth is a parameter: 3 gives 8 states and 4 gives 16 states. The feedback polynomial, the main feedforward polynomial and the auxiliary feedforward polynomial are parameters whose defaults follow the chosen depth. The block raises a ready output only when it can take a new pair without a gap or an overrun in the serial stream.

Top module: `pccc_encoder`

## Requirements
- R1: After reset `out_vld` is 0 and `in_rdy` is 1, and both encoder registers hold zero.
- R2: Rate code 2'b00 (rate 1/3, the zero code) emits, for each pair, the systematic bit, then encoder 1 parity, then encoder 2 parity.
- R3: Rate code 2'b01 (rate 1/2) emits the systematic bit, then one parity bit. The parity comes from encoder 1 on even bit indices and from encoder 2 on odd bit indices, and the first bit of a block has index 0.
- R4: Rate code 2'b10 (rate 1/4) emits the systematic bit, encoder 1 parity and encoder 2 parity, then the auxiliary parity bit. The auxiliary parity comes from encoder 1 on even indices and from encoder 2 on odd indices.
- R5: Rate code 2'b11 (rate 1/6) emits the systematic bit, encoder 1 parity, encoder 1 auxiliary parity, encoder 2 parity, encoder 2 auxiliary parity, then the systematic bit again.
- R6: Polynomials are written with the most significant bit as the undelayed tap and bit MEM-k as the tap of delay k. The feedback value is the input XOR the tapped state bits. Each parity is its polynomial applied to the feedback value and the state. The defaults are: for MEM=3, feedback 1011, main 1101 and auxiliary 1111; for MEM=4, feedback 10011, main 11011 and auxiliary 11111.
- R7: After the group of the pair flagged last, encoder 1 takes MEM tail steps and then encoder 2 takes MEM tail steps. Each step emits three bits regardless of rate: the tail input (equal to the feedback sum), the main parity and the auxiliary parity. `in_rdy` stays low throughout, the encoder that is not stepping holds its state, and both registers are zero afterwards.
- R8: Encoder 2 is fed only from `in_perm`. Its input bit is never sent during the data phase.
- R9: `in_rdy` is high only in the data phase when at most one bit of the current group is still to be sent. An accepted pair starts its group on the next clock, so the stream has no gaps, and a strobe while `in_rdy` is low has no effect.
- R10: Every block, including one that starts after a reset in mid-block, starts from zero state in both encoders and at bit index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate | input | 2 | Rate select, sampled with each accepted pair |
| in_sys | input | 1 | Natural-order data bit |
| in_perm | input | 1 | Permuted-order data bit |
| in_vld | input | 1 | Pair strobe |
| in_last | input | 1 | Marks the final pair of a block |
| in_rdy | output | 1 | Block can accept a pair this cycle |
| out_bit | output | 1 | Serial coded bit |
| out_vld | output | 1 | `out_bit` is valid |

## Verification
The bench targets the alternation index at rates 1/2 and 1/4. A design that did not reset the index between blocks would pick the wrong encoder for every parity of the second block. Blocks of length 1 and 2 check that a block whose first pair is also its last still terminates correctly. A design that terminated both encoders at once, or punctured the tail by rate, would give tail slices of the wrong length or content. Strobes held high while `in_rdy` is low, and a reset in mid-block, expose a design that takes extra pairs or carries state into the next block: the whole coded stream of that block would then differ.

// File: rtl/pccc_pkg.sv
package pccc_pkg;
  localparam int MAXMEM = 4;

  typedef enum logic [1:0] {
    RATE_THIRD   = 2'b00,
    RATE_HALF    = 2'b01,
    RATE_QUARTER = 2'b10,
    RATE_SIXTH   = 2'b11
  } rate_e;

  typedef enum logic {PH_DATA, PH_TAIL} phase_e;

  // State bit k-1 holds the value delayed by k; its tap is poly[mem-k].
  function automatic logic [MAXMEM-1:0] tap_mask(input logic [MAXMEM:0] poly, input int mem);
    tap_mask = '0;
    for (int k = 1; k <= MAXMEM; k++)
      if (k <= mem) tap_mask[k-1] = poly[mem-k];
  endfunction
endpackage

// File: rtl/pccc_rsc.sv
module pccc_rsc
  import pccc_pkg::*;
#(
  parameter int MEM = 3,
  parameter logic [MAXMEM:0] FB  = 5'b01011,
  parameter logic [MAXMEM:0] FFA = 5'b01101,
  parameter logic [MAXMEM:0] FFB = 5'b01111
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           u,
  input  logic           term,
  input  logic           adv,
  output logic           x,
  output logic           pa,
  output logic           pb,
  output logic [MEM-1:0] st
);
  localparam logic [MAXMEM-1:0] FBW = tap_mask(FB, MEM);
  localparam logic [MAXMEM-1:0] FAW = tap_mask(FFA, MEM);
  localparam logic [MAXMEM-1:0] FBB = tap_mask(FFB, MEM);

  logic fbs, a;

  always_comb begin
    fbs = ^(st & FBW[MEM-1:0]);
    x   = term ? fbs : u;
    a   = x ^ fbs;
    pa  = (FFA[MEM] & a) ^ (^(st & FAW[MEM-1:0]));
    pb  = (FFB[MEM] & a) ^ (^(st & FBB[MEM-1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= '0;
    else if (adv) st <= {st[MEM-2:0], a};
  end
endmodule

// File: rtl/pccc_punct.sv
module pccc_punct
  import pccc_pkg::*;
(
  input  rate_e      rate,
  input  logic       odd,
  input  logic       tail,
  input  logic       x1,
  input  logic       p1,
  input  logic       q1,
  input  logic       p2,
  input  logic       q2,
  input  logic       tx,
  input  logic       tp,
  input  logic       tq,
  output logic [5:0] bits,
  output logic [2:0] cnt
);
  // bits[0] leaves first
  always_comb begin
    bits = '0;
    cnt  = 3'd3;
    if (tail) begin
      bits[2:0] = {tq, tp, tx};
    end else begin
      case (rate)
        RATE_HALF: begin
          bits[1:0] = {odd ? p2 : p1, x1};
          cnt       = 3'd2;
        end
        RATE_QUARTER: begin
          bits[3:0] = {odd ? q2 : q1, p2, p1, x1};
          cnt       = 3'd4;
        end
        RATE_SIXTH: begin
          bits = {x1, q2, p2, q1, p1, x1};
          cnt  = 3'd6;
        end
        default: bits[2:0] = {p2, p1, x1};
      endcase
    end
  end
endmodule

// File: rtl/pccc_encoder.sv
module pccc_encoder
  import pccc_pkg::*;
#(
  parameter int MEM = 3,
  parameter logic [MAXMEM:0] FB      = (MEM == 4) ? 5'b10011 : 5'b01011,
  parameter logic [MAXMEM:0] FF_MAIN = (MEM == 4) ? 5'b11011 : 5'b01101,
  parameter logic [MAXMEM:0] FF_AUX  = (MEM == 4) ? 5'b11111 : 5'b01111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate,
  input  logic       in_sys,
  input  logic       in_perm,
  input  logic       in_vld,
  input  logic       in_last,
  output logic       in_rdy,
  output logic       out_bit,
  output logic       out_vld
);
  localparam int TW = $clog2(2 * MEM);

  phase_e         ph;
  logic [TW-1:0]  tix;
  logic [2:0]     left;
  logic [5:0]     sh;
  logic           odd, fresh;

  // named events
  logic free, acc, tail_step, tail_e2, tail_done;
  logic x1, p1, q1, x2, p2, q2;
  logic [MEM-1:0] st1, st2;
  logic [5:0] pbits;
  logic [2:0] pcnt;

  assign free      = (left <= 3'd1);
  assign in_rdy    = free && (ph == PH_DATA);
  assign acc       = in_vld && in_rdy;
  assign tail_step = free && (ph == PH_TAIL);
  assign tail_e2   = (tix >= TW'(MEM));
  assign tail_done = tail_step && (tix == TW'(2 * MEM - 1));

  pccc_rsc #(.MEM(MEM), .FB(FB), .FFA(FF_MAIN), .FFB(FF_AUX)) u_enc1 (
    .clk(clk), .rst_n(rst_n), .u(in_sys), .term(ph == PH_TAIL),
    .adv(acc || (tail_step && !tail_e2)),
    .x(x1), .pa(p1), .pb(q1), .st(st1)
  );

  pccc_rsc #(.MEM(MEM), .FB(FB), .FFA(FF_MAIN), .FFB(FF_AUX)) u_enc2 (
    .clk(clk), .rst_n(rst_n), .u(in_perm), .term(ph == PH_TAIL),
    .adv(acc || (tail_step && tail_e2)),
    .x(x2), .pa(p2), .pb(q2), .st(st2)
  );

  pccc_punct u_punct (
    .rate(rate_e'(rate)), .odd(odd), .tail(ph == PH_TAIL),
    .x1(x1), .p1(p1), .q1(q1), .p2(p2), .q2(q2),
    .tx(tail_e2 ? x2 : x1), .tp(tail_e2 ? p2 : p1), .tq(tail_e2 ? q2 : q1),
    .bits(pbits), .cnt(pcnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (acc || tail_step) begin
      sh   <= pbits;
      left <= pcnt;
    end else if (left != 3'd0) begin
      sh   <= sh >> 1;
      left <= left - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_DATA;
      tix   <= '0;
      odd   <= 1'b0;
      fresh <= 1'b1;
    end else begin
      if (acc) begin
        odd   <= ~odd;
        fresh <= 1'b0;
        if (in_last) begin
          ph  <= PH_TAIL;
          tix <= '0;
        end
      end
      if (tail_step) begin
        tix <= tix + TW'(1);
        if (tail_done) begin
          ph    <= PH_DATA;
          odd   <= 1'b0;
          fresh <= 1'b1;
        end
      end
    end
  end

  assign out_bit = sh[0];
  assign out_vld = (left != 3'd0);
endmodule

// File: rtl/pccc_encoder_chk.sv
module pccc_encoder_chk #(
  parameter int MEM = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic           in_last,
  input logic           in_rdy,
  input logic           out_vld,
  input logic           acc,
  input logic           tail_step,
  input logic           tail_e2,
  input logic           tail_done,
  input logic           fresh,
  input logic [MEM-1:0] st1,
  input logic [MEM-1:0] st2
);
  a_r7_zero_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    tail_done |=> (st1 == '0) && (st2 == '0));

  a_r7_enc2_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_step && !tail_e2) |=> $stable(st2));

  a_r7_enc1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_step && tail_e2) |=> $stable(st1));

  a_r7_no_rdy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last) |=> !in_rdy);

  a_r9_no_rdy_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    tail_step |-> !in_rdy);

  a_r9_output_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && acc) |=> out_vld);

  a_r10_block_starts_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fresh) |-> (st1 == '0) && (st2 == '0));
endmodule

bind pccc_encoder pccc_encoder_chk #(.MEM(MEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_last(in_last),
  .in_rdy(in_rdy), .out_vld(out_vld), .acc(acc), .tail_step(tail_step),
  .tail_e2(tail_e2), .tail_done(tail_done), .fresh(fresh),
  .st1(st1), .st2(st2)
);

// File: tb/pccc_encoder_test.sv
`timescale 1ns/1ps
module pccc_encoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rate = 2'b00;
  logic in_sys = 1'b0, in_perm = 1'b0, in_vld = 1'b0, in_last = 1'b0;
  logic in_rdy, out_bit, out_vld;

  pccc_encoder uut (
    .clk(clk), .rst_n(rst_n), .rate(rate), .in_sys(in_sys), .in_perm(in_perm),
    .in_vld(in_vld), .in_last(in_last), .in_rdy(in_rdy),
    .out_bit(out_bit), .out_vld(out_vld)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit sysb [0:63];
  bit permb[0:63];
  bit expb [0:511];
  bit gotb [0:511];
  int nexp, ngot;

  // stimulus table: rate, length, seed
  localparam int NV = 8;
  localparam logic [1:0]  V_RATE [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b11};
  localparam int          V_LEN  [NV] = '{1, 5, 8, 2, 40, 17, 13, 24};
  localparam logic [15:0] V_SEED [NV] = '{16'hACE1, 16'h1234, 16'hBEEF, 16'h0F0F,
                                          16'h5A5A, 16'h7777, 16'h2468, 16'hC3C3};

  always @(negedge clk)
    if (out_vld && ngot < 512) begin
      gotb[ngot] = out_bit;
      ngot++;
    end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // independent encoder model, 8-state defaults: fb 1011, main 1101, aux 1111
  function automatic void enc_step(input bit u, input bit tail, inout bit [1:3] r,
                                   output bit x, output bit p, output bit q);
    bit fb, a;
    fb = r[2] ^ r[3];
    x  = tail ? fb : u;
    a  = x ^ fb;
    p  = a ^ r[1] ^ r[3];
    q  = a ^ r[1] ^ r[2] ^ r[3];
    r  = {a, r[1], r[2]};
  endfunction

  function automatic string rate_req(input logic [1:0] r);
    case (r)
      2'b01: return "R3";
      2'b10: return "R4";
      2'b11: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic gen_bits(input logic [15:0] seed, input int len);
    logic [15:0] l = seed;
    for (int i = 0; i < len; i++) begin
      sysb[i]  = l[0];
      permb[i] = l[7] ^ l[1];
      l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
    end
  endtask

  task automatic push(input bit b);
    expb[nexp] = b;
    nexp++;
  endtask

  task automatic build_expected(input logic [1:0] r, input int len);
    bit [1:3] e1 = '0, e2 = '0;
    bit x1, p1, q1, x2, p2, q2;
    nexp = 0;
    for (int i = 0; i < len; i++) begin
      enc_step(sysb[i], 1'b0, e1, x1, p1, q1);
      enc_step(permb[i], 1'b0, e2, x2, p2, q2);
      push(x1);
      case (r)
        2'b01: push((i % 2) ? p2 : p1);
        2'b10: begin push(p1); push(p2); push((i % 2) ? q2 : q1); end
        2'b11: begin push(p1); push(q1); push(p2); push(q2); push(x1); end
        default: begin push(p1); push(p2); end
      endcase
    end
    for (int k = 0; k < 3; k++) begin
      enc_step(1'b0, 1'b1, e1, x1, p1, q1);
      push(x1); push(p1); push(q1);
    end
    for (int k = 0; k < 3; k++) begin
      enc_step(1'b0, 1'b1, e2, x2, p2, q2);
      push(x2); push(p2); push(q2);
    end
  endtask

  task automatic drive_block(input logic [1:0] r, input int len, input bit noise);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!in_rdy) begin
        in_vld  = noise;
        in_sys  = ~sysb[i];
        in_perm = ~permb[i];
        in_last = noise;
        @(negedge clk);
      end
      rate    = r;
      in_sys  = sysb[i];
      in_perm = permb[i];
      in_last = (i == len - 1);
      in_vld  = 1'b1;
    end
    @(negedge clk);
    in_vld  = 1'b0;
    in_last = 1'b0;
    check("R7 ready low after last pair", int'(in_rdy), 0);
  endtask

  task automatic run_case(input logic [1:0] r, input int len, input logic [15:0] seed,
                          input bit noise, input string label);
    int bad;
    gen_bits(seed, len);
    build_expected(r, len);
    @(negedge clk);
    ngot = 0;
    drive_block(r, len, noise);
    for (int t = 0; t < 400 && ngot < nexp; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check({label, " coded length"}, ngot, nexp);
    bad = -1;
    for (int i = 0; i < nexp - 18; i++)
      if (bad < 0 && gotb[i] != expb[i]) bad = i;
    if (bad >= 0) check({label, " data bit"}, int'(gotb[bad]), int'(expb[bad]));
    else          check({label, " data bits"}, 0, 0);
    bad = -1;
    for (int i = nexp - 18; i < nexp; i++)
      if (bad < 0 && gotb[i] != expb[i]) bad = i;
    if (bad >= 0) check("R7 tail bit", int'(gotb[bad]), int'(expb[bad]));
    else          check("R7 tail bits", 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_vld after reset", int'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_vld idle", int'(out_vld), 0);
    check("R1 in_rdy idle", int'(in_rdy), 1);

    for (int v = 0; v < NV; v++)
      run_case(V_RATE[v], V_LEN[v], V_SEED[v], 1'b0,
               {rate_req(V_RATE[v]), " R6 R8"});

    // same block twice in a row: both must match a zero-state start
    run_case(2'b01, 9, 16'h9999, 1'b0, "R10 first");
    run_case(2'b01, 9, 16'h9999, 1'b0, "R10 repeat");

    // strobes with junk data while not ready
    run_case(2'b11, 6, 16'h3141, 1'b1, "R9 ignored strobes");
    run_case(2'b10, 7, 16'h2718, 1'b1, "R9 ignored strobes q");

    // reset in mid-block, then a clean block
    gen_bits(16'h4242, 4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      while (!in_rdy) @(negedge clk);
      rate = 2'b00; in_sys = sysb[i]; in_perm = permb[i]; in_last = 1'b0; in_vld = 1'b1;
    end
    @(negedge clk);
    in_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 out_vld in reset", int'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_rdy after reset", int'(in_rdy), 1);
    run_case(2'b10, 11, 16'h6161, 1'b0, "R10 after reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule